// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over one bidirectional, open-drain smart card I/O line. It works in half duplex. A start request sends a byte. A falling edge seen on the idle line begins the reception of a byte. Each frame has a low start bit, eight data bits and an even parity bit. A timing strobe sets the bit period: it pulses four times per elementary time unit (etu). The bit order and the meaning of the line level follow one of two conventions, chosen by a mode input.

With the repetition mode on, the receiver pulls the line low in the guard time of a character whose parity is wrong. The transmitter watches the same window and sends the character again when the card pulls the line low. A select input sets how many attempts are made before the sticky parity error flag is set. The flag drives an interrupt request when that interrupt is enabled. Another control input hands the line to a plain software-driven level instead of the transceiver. A soft reset input holds everything idle and clears the flag.

Top module: `sc_char_xcvr`

## Requirements
- R1: While `rst_ni` is low, and one cycle after `soft_rst_i` is high, `busy_o`, `perr_o` and `rx_valid_o` are 0. While `soft_rst_i` is high, `io_oe_o` is 0.
- R2: With `inverse_i`=0, one cycle after `tx_start_i` is taken in idle, `busy_o` goes to 1 and the line sends etu 0 low. Etu k=1..8 then carry data bit k-1 with no inversion, and etu 9 carries the even parity of the byte (XOR of all eight bits). The line is released from etu 10 onward. Etu k holds from tick 4k to tick 4k+3 after the accepting edge.
- R3: With `inverse_i`=1, etu k=1..8 carry the complement of data bit 8-k, and etu 9 carries the complement of the even parity bit. The start bit is still low.
- R4: A low line seen on a tick while idle starts a reception. That tick is tick 0. Etu k is sampled at tick 4k+2. At tick 52 the frame ends. If the character is accepted, `rx_valid_o` pulses for one cycle and `rx_data_o` holds the byte, decoded by the same convention as R2 and R3.
- R5: With `rep_en_i`=1, a received character with bad parity makes `io_oe_o` drive the line low from tick 42 up to but not including tick 48. A character with good parity leaves the line released.
- R6: With `rep_en_i`=1, a bad character is not delivered but counts one attempt. The attempt that reaches 4 (`rep_sel_i`=0) or 5 (`rep_sel_i`=1) still gets the low indication, is delivered, and sets `perr_o`.
- R7: With `rep_en_i`=1, the transmitter samples the line at tick 46. When it is low there, the character is sent again from tick 52. After 3 (`rep_sel_i`=0) or 4 (`rep_sel_i`=1) repeats that also fail, it stops and sets `perr_o`. A new `tx_start_i` clears the attempt count.
- R8: With `rep_en_i`=0, a bad received character gets no indication. It is delivered at once and sets `perr_o`. A low line at tick 46 of a transmission causes no repeat and leaves `perr_o` unchanged.
- R9: `irq_o` equals `perr_o` while `par_irq_en_i` is 1 and is 0 otherwise.
- R10: `perr_o` stays set until `perr_clr_i` or `soft_rst_i` is high.
- R11: With `xcvr_sel_i`=0, the line follows `sw_line_i` (`io_oe_o` = NOT `sw_line_i`). The transceiver stays idle and ignores `tx_start_i` and line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Control reset, holds block idle, active high |
| xcvr_sel_i | input | 1 | 1: transceiver owns the line, 0: software level owns it |
| sw_line_i | input | 1 | Software line level |
| inverse_i | input | 1 | 1: inverse convention |
| rep_en_i | input | 1 | Error indication and repetition enable |
| rep_sel_i | input | 1 | Attempt limit select |
| par_irq_en_i | input | 1 | Parity interrupt enable |
| perr_clr_i | input | 1 | Clears the parity error flag |
| tick_i | input | 1 | Quarter-etu strobe |
| tx_start_i | input | 1 | Send request, taken when idle |
| tx_data_i | input | 8 | Byte to send |
| io_i | input | 1 | Sensed line level |
| io_oe_o | output | 1 | Pull line low when 1 |
| busy_o | output | 1 | Frame in progress |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| perr_o | output | 1 | Sticky parity error flag |
| irq_o | output | 1 | Parity interrupt request |

## Verification
The hardest case to reach is the last attempt of a repetition run. The attempt count must land exactly on its limit, through back-to-back frames that are each nacked or corrupted, under both limit selects. The bench works as a card model. It drives the shared line by tick count and corrupts or nacks the first N frames, with N drawn at random from 0 to 5. This covers runs that recover before the limit, that end exactly on it, and that go past it. Its expected frame count and flag come from a bench function of N and the select.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned PW = $clog2(DW);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } xcvr_st_e;

  function automatic logic even_par(input logic [DW-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_tx_enc.sv
module sc_tx_enc
  import sc_xcvr_pkg::*;
#(
  parameter int unsigned EW = 4
) (
  input  logic [EW-1:0] etu_i,
  input  logic [DW-1:0] data_i,
  input  logic          inverse_i,
  output logic          level_o
);
  logic [PW-1:0] pos;

  always_comb begin
    pos     = PW'(etu_i - EW'(1));
    level_o = 1'b1;
    if (etu_i == '0) begin
      level_o = 1'b0;
    end else if (etu_i <= EW'(DW)) begin
      level_o = (inverse_i ? data_i[PW'(DW-1) - pos] : data_i[pos]) ^ inverse_i;
    end else if (etu_i == EW'(DW+1)) begin
      level_o = even_par(data_i) ^ inverse_i;
    end
  end
endmodule

// File: rtl/sc_rx_dec.sv
module sc_rx_dec
  import sc_xcvr_pkg::*;
#(
  parameter int unsigned EW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_i,
  input  logic [EW-1:0] etu_i,
  input  logic          line_i,
  input  logic          inverse_i,
  output logic [DW-1:0] data_o,
  output logic          par_ok_o
);
  logic [DW-1:0] raw_q;
  logic          praw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      praw_q <= 1'b0;
    end else if (smp_i) begin
      if (etu_i >= EW'(1) && etu_i <= EW'(DW)) raw_q[PW'(etu_i - EW'(1))] <= line_i;
      else if (etu_i == EW'(DW+1))             praw_q <= line_i;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_map
    assign data_o[i] = inverse_i ? ~raw_q[DW-1-i] : raw_q[i];
  end

  assign par_ok_o = ~(even_par(data_o) ^ praw_q ^ inverse_i);
endmodule

// File: rtl/sc_rep_ctr.sv
module sc_rep_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int unsigned OVS       = 4,
  parameter int unsigned FRAME_ETU = 13,
  parameter int unsigned REP_W     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          xcvr_sel_i,
  input  logic          sw_line_i,
  input  logic          inverse_i,
  input  logic          rep_en_i,
  input  logic          rep_sel_i,
  input  logic          par_irq_en_i,
  input  logic          perr_clr_i,
  input  logic          tick_i,
  input  logic          tx_start_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          io_i,
  output logic          io_oe_o,
  output logic          busy_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          perr_o,
  output logic          irq_o
);
  localparam int unsigned OB      = $clog2(OVS);
  localparam int unsigned FT      = FRAME_ETU * OVS;
  localparam int unsigned CW      = $clog2(FT);
  localparam int unsigned EW      = CW - OB;
  localparam int unsigned SMP     = OVS / 2 - 1;
  localparam int unsigned PDEC    = (DW + 2) * OVS;
  localparam int unsigned ERR_LO  = (DW + 2) * OVS + OVS / 2;
  localparam int unsigned ERR_HI  = (DW + 4) * OVS;
  localparam int unsigned NACK_PT = (DW + 3) * OVS + SMP;
  localparam int unsigned LAST    = FT - 1;

  xcvr_st_e        st_q;
  logic [CW-1:0]   cnt_q;
  logic [EW-1:0]   etu;
  logic            nack_q;
  logic [DW-1:0]   data_q;
  logic            rx_valid_q;
  logic [DW-1:0]   rx_data_q;
  logic            perr_q;
  logic            active, at_smp, at_last;
  logic            tx_level, dec_ok;
  logic [DW-1:0]   dec_data;
  logic [REP_W-1:0] rep_cnt, lim_tx, lim_rx;
  logic            tx_end, rx_end, tx_retry, tx_fail, rx_retry, rx_fail, rx_deliver;
  logic            rep_clr, rep_inc;

  assign active  = !soft_rst_i && xcvr_sel_i;
  assign etu     = cnt_q[CW-1:OB];
  assign at_smp  = tick_i && (cnt_q[OB-1:0] == OB'(SMP));
  assign at_last = cnt_q == CW'(LAST);
  assign lim_tx  = rep_sel_i ? REP_W'(4) : REP_W'(3);
  assign lim_rx  = rep_sel_i ? REP_W'(5) : REP_W'(4);

  assign tx_end     = active && tick_i && at_last && (st_q == ST_TX);
  assign rx_end     = active && tick_i && at_last && (st_q == ST_RX);
  assign tx_retry   = tx_end && nack_q && rep_en_i && (rep_cnt != lim_tx);
  assign tx_fail    = tx_end && nack_q && rep_en_i && (rep_cnt == lim_tx);
  assign rx_retry   = rx_end && nack_q && rep_en_i && ((rep_cnt + REP_W'(1)) != lim_rx);
  assign rx_fail    = rx_end && nack_q && (!rep_en_i || ((rep_cnt + REP_W'(1)) == lim_rx));
  assign rx_deliver = rx_end && !rx_retry;
  assign rep_inc    = tx_retry || rx_retry;
  assign rep_clr    = !active || ((st_q == ST_IDLE) && tx_start_i)
                    || (tx_end && !tx_retry) || (rx_end && !rx_retry);

  sc_tx_enc #(.EW(EW)) u_enc (
    .etu_i     (etu),
    .data_i    (data_q),
    .inverse_i (inverse_i),
    .level_o   (tx_level)
  );

  sc_rx_dec #(.EW(EW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (at_smp && active && (st_q == ST_RX)),
    .etu_i     (etu),
    .line_i    (io_i),
    .inverse_i (inverse_i),
    .data_o    (dec_data),
    .par_ok_o  (dec_ok)
  );

  sc_rep_ctr #(.CNT_W(REP_W)) u_rep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rep_clr),
    .inc_i  (rep_inc),
    .cnt_o  (rep_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      nack_q     <= 1'b0;
      data_q     <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      perr_q     <= 1'b0;
    end else begin
      rx_valid_q <= rx_deliver;
      if (rx_deliver) rx_data_q <= dec_data;

      if (soft_rst_i)              perr_q <= 1'b0;
      else if (tx_fail || rx_fail) perr_q <= 1'b1;
      else if (perr_clr_i)         perr_q <= 1'b0;

      if (!active) begin
        st_q   <= ST_IDLE;
        cnt_q  <= '0;
        nack_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (tx_start_i) begin
              st_q   <= ST_TX;
              cnt_q  <= '0;
              nack_q <= 1'b0;
              data_q <= tx_data_i;
            end else if (tick_i && !io_i) begin
              st_q   <= ST_RX;
              cnt_q  <= '0;
              nack_q <= 1'b0;
            end
          end
          ST_TX: begin
            if (tick_i) begin
              if (cnt_q == CW'(NACK_PT) && !io_i) nack_q <= 1'b1;
              if (at_last) begin
                cnt_q  <= '0;
                nack_q <= 1'b0;
                if (!tx_retry) st_q <= ST_IDLE;
              end else begin
                cnt_q <= cnt_q + CW'(1);
              end
            end
          end
          ST_RX: begin
            if (tick_i) begin
              if (cnt_q == CW'(SMP) && io_i) begin
                st_q <= ST_IDLE;   // glitch, not a start bit
              end else if (at_last) begin
                st_q <= ST_IDLE;
              end else begin
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == CW'(PDEC)) nack_q <= !dec_ok;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (soft_rst_i)       io_oe_o = 1'b0;
    else if (!xcvr_sel_i) io_oe_o = !sw_line_i;
    else io_oe_o = ((st_q == ST_TX) && (etu < EW'(DW+2)) && !tx_level)
                 || ((st_q == ST_RX) && nack_q && rep_en_i
                     && (cnt_q >= CW'(ERR_LO)) && (cnt_q < CW'(ERR_HI)));
  end

  assign busy_o     = st_q != ST_IDLE;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign perr_o     = perr_q;
  assign irq_o      = perr_q && par_irq_en_i;
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic xcvr_sel_i,
  input logic perr_clr_i,
  input logic busy_o,
  input logic perr_o,
  input logic rx_valid_o,
  input logic io_oe_o
);
  assert_srst_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!busy_o && !perr_o));

  assert_drive_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o && xcvr_sel_i && !soft_rst_i) |-> busy_o);

  assert_rx_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_perr_from_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> $past(busy_o));

  assert_perr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o && !perr_clr_i && !soft_rst_i) |=> perr_o);

  assert_sw_mode_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xcvr_sel_i |=> !busy_o);
endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .xcvr_sel_i (xcvr_sel_i),
  .perr_clr_i (perr_clr_i),
  .busy_o     (busy_o),
  .perr_o     (perr_o),
  .rx_valid_o (rx_valid_o),
  .io_oe_o    (io_oe_o)
);

// File: tb/sim_sc_char_xcvr.sv
module sim_sc_char_xcvr;
  localparam int CLK_P = 10;
  localparam int OVS   = 4;
  localparam int TDIV  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 1'b0, xsel = 1'b1, sw_line = 1'b1, inv = 1'b0;
  logic rep_en = 1'b0, rep_sel = 1'b0, irq_en = 1'b0, perr_clr = 1'b0;
  logic tick = 1'b0, tx_start = 1'b0, card_pull = 1'b0;
  logic [7:0] tx_data = '0;
  logic io, io_oe, busy, rx_valid, perr, irq;
  logic [7:0] rx_data;
  int n_chk = 0, n_err = 0, pos = 0;

  always #(CLK_P/2) clk = ~clk;
  assign io = ~(io_oe | card_pull);

  sc_char_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .xcvr_sel_i(xsel),
    .sw_line_i(sw_line), .inverse_i(inv), .rep_en_i(rep_en), .rep_sel_i(rep_sel),
    .par_irq_en_i(irq_en), .perr_clr_i(perr_clr), .tick_i(tick),
    .tx_start_i(tx_start), .tx_data_i(tx_data), .io_i(io), .io_oe_o(io_oe),
    .busy_o(busy), .rx_valid_o(rx_valid), .rx_data_o(rx_data), .perr_o(perr),
    .irq_o(irq)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick = (div == TDIV-1);
      div  = (div == TDIV-1) ? 0 : div + 1;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_P*190000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic lvl(input logic [7:0] d, input int k, input bit iv, input bit flip);
    if (k == 0) return 1'b0;
    if (k <= 8) return (iv ? d[8-k] : d[k-1]) ^ iv;
    if (k == 9) return (^d) ^ iv ^ flip;
    return 1'b1;
  endfunction

  task automatic tk_wait(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic to_tick(input int j);
    tk_wait(j - pos);
    pos = j;
  endtask

  task automatic clr_perr();
    perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0;
    chk(perr == 1'b0, "R10", perr, 0);
  endtask

  task automatic do_tx(input logic [7:0] d, input bit iv, input bit re, input bit rs, input int nack_n);
    logic [9:0] lv, ev;
    int lim;
    bit nk, cont;
    lim = rs ? 4 : 3;
    inv = iv; rep_en = re; rep_sel = rs; tx_data = d;
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0; pos = 0;
    chk(busy == 1'b1, iv ? "R3" : "R2", busy, 1);
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 10; k++) begin
        to_tick(k*OVS + 2);
        lv[k] = io;
        ev[k] = lvl(d, k, iv, 1'b0);
      end
      chk(lv == ev, iv ? "R3" : "R2", lv, ev);
      nk = (f < nack_n);
      if (nk) begin
        to_tick(42); card_pull = 1'b1;
        to_tick(48); card_pull = 1'b0;
      end
      to_tick(52);
      pos  = 0;
      cont = re && nk && (f < lim);
      chk(busy == cont, re ? "R7" : "R8", busy, cont);
      if (!cont) begin
        chk(perr == (re && nk), re ? "R7" : "R8", perr, re && nk);
        break;
      end
    end
  endtask

  task automatic do_rx(input logic [7:0] d, input bit iv, input bit re, input bit rs, input int bad_n);
    int lim;
    bit bad, retry, ef;
    lim = rs ? 5 : 4;
    inv = iv; rep_en = re; rep_sel = rs;
    for (int f = 0; f < 8; f++) begin
      bad = (f < bad_n);
      card_pull = 1'b1;
      tk_wait(1); pos = 0;
      for (int k = 1; k < 10; k++) begin
        to_tick(k*OVS);
        card_pull = !lvl(d, k, iv, bad);
      end
      to_tick(40); card_pull = 1'b0;
      to_tick(44);
      chk(io_oe == (bad && re), re ? "R5" : "R8", io_oe, bad && re);
      to_tick(52);
      retry = bad && re && (f + 1 < lim);
      chk(rx_valid == !retry, "R4", rx_valid, !retry);
      if (!retry) begin
        chk(rx_data == d, "R4", rx_data, d);
        ef = bad && (!re || (f + 1 == lim));
        chk(perr == ef, re ? "R6" : "R8", perr, ef);
        break;
      end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h51C0);
    repeat (4) @(negedge clk);
    chk(io_oe == 1'b0 && busy == 1'b0, "R1", {io_oe, busy}, 0);
    chk(perr == 1'b0 && rx_valid == 1'b0 && irq == 1'b0, "R1", {perr, rx_valid, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_tx(8'hA5, 1'b0, 1'b0, 1'b0, 0);   // R2
    do_tx(8'h3B, 1'b1, 1'b0, 1'b0, 0);   // R3
    do_rx(8'h96, 1'b0, 1'b1, 1'b0, 0);   // R4
    do_rx(8'h0F, 1'b1, 1'b1, 1'b0, 0);   // R4 inverse
    do_rx(8'h5C, 1'b0, 1'b1, 1'b0, 9);   // R5 R6 limit 4
    clr_perr();
    do_rx(8'hC3, 1'b1, 1'b1, 1'b1, 9);   // R6 limit 5
    clr_perr();
    do_tx(8'h81, 1'b0, 1'b1, 1'b0, 9);   // R7 three repeats
    clr_perr();
    do_tx(8'h7E, 1'b1, 1'b1, 1'b1, 9);   // R7 four repeats
    clr_perr();
    do_tx(8'h42, 1'b0, 1'b1, 1'b0, 2);   // R7 recovers
    do_tx(8'h24, 1'b0, 1'b0, 1'b0, 1);   // R8 nack ignored
    do_rx(8'h99, 1'b0, 1'b0, 1'b0, 1);   // R8 no indication

    // R9 R10 sticky flag and interrupt
    irq_en = 1'b0; @(negedge clk);
    chk(irq == 1'b0, "R9", irq, 0);
    tk_wait(20);
    chk(perr == 1'b1, "R10", perr, 1);
    irq_en = 1'b1; @(negedge clk);
    chk(irq == 1'b1, "R9", irq, 1);
    clr_perr();
    chk(irq == 1'b0, "R9", irq, 0);

    // R1 soft reset mid frame with flag set
    do_rx(8'h11, 1'b0, 1'b0, 1'b0, 1);
    tx_data = 8'h00; tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    tk_wait(5);
    soft_rst = 1'b1; @(negedge clk);
    chk(busy == 1'b0 && perr == 1'b0 && io_oe == 1'b0, "R1", {busy, perr, io_oe}, 0);
    soft_rst = 1'b0; @(negedge clk);

    // R11 software line control
    xsel = 1'b0; sw_line = 1'b0; @(negedge clk);
    chk(io == 1'b0, "R11", io, 0);
    sw_line = 1'b1; @(negedge clk);
    chk(io == 1'b1, "R11", io, 1);
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    card_pull = 1'b1; tk_wait(3);
    chk(busy == 1'b0, "R11", busy, 0);
    card_pull = 1'b0; xsel = 1'b1; tk_wait(2);

    for (int t = 0; t < 20; t++) begin
      logic [7:0] d;
      bit iv, re, rs, dir;
      int n;
      d = 8'($urandom); iv = 1'($urandom); re = 1'($urandom);
      rs = 1'($urandom); dir = 1'($urandom); n = $urandom_range(0, 5);
      irq_en = 1'($urandom);
      if (dir) do_tx(d, iv, re, rs, n);
      else     do_rx(d, iv, re, rs, n);
      chk(irq == (perr && irq_en), "R9", irq, perr && irq_en);
      clr_perr();
    end

    report();
    $finish;
  end
endmodule